// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two W-bit integers (32 by default) over W clock cycles and delivers the 2W-bit product as an upper word and a lower word. A single 2W-bit accumulator holds both the shrinking multiplier and the growing partial product. The multiplier is loaded into the low half and the high half starts at zero. Each cycle a W-bit adder/subtractor may fold the held multiplicand into the high half, and then the whole accumulator moves one place to the right. The adder's extra bit becomes the new top bit. The multiplicand itself never moves.

A caller pulses the start input while the block is idle and supplies both operands and a signed/unsigned select in that same cycle. The busy output then stays high while the work is in progress. A one-cycle done pulse marks the cycle in which the new product first appears on the hi/lo outputs. In signed mode the partial product is sign-extended as it shifts. On the final step, where the multiplier's sign bit is examined, the multiplicand is subtracted rather than added, which gives a correct two's-complement result.

Top module: `seq_mul`

## Requirements
- R1: After reset, busy_o and done_o are 0, and hi_o and lo_o are all zeros.
- R2: With signed_i = 0 at start, {hi_o, lo_o} equals the unsigned product of the two operands, with hi_o the upper W bits.
- R3: With signed_i = 1 at start, {hi_o, lo_o} equals the two's-complement product of the operands read as signed W-bit values, including the most negative value times itself.
- R4: done_o is high for exactly one cycle, and it rises W cycles after the clock edge that accepted the start.
- R5: busy_o is high from the cycle after an accepted start up to, but not including, the cycle in which done_o is high.
- R6: A start pulse while busy_o is high is ignored. The running operation keeps its timing and its result.
- R7: hi_o and lo_o change only in a cycle where done_o is high. At all other times they keep the last product.
- R8: The operands and the signed select are captured at the accepted start. Later changes on those inputs do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication (taken only when idle) |
| signed_i | input | 1 | 1: operands are two's complement; 0: unsigned |
| mcand_i | input | W | Multiplicand |
| mplier_i | input | W | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: a new product is on hi_o/lo_o |
| hi_o | output | W | Upper half of the last product |
| lo_o | output | W | Lower half of the last product |

## Verification
The properties take it for granted that the operand and select inputs are valid whenever start_i is high. They also assume that a start during busy is the only way a caller can overlap work, so the busy-cycle count can never exceed W. The stimulus drives every input on the falling clock edge and asserts start for exactly one cycle. It includes deliberate starts during busy and operand changes mid-operation, to confirm that these are ignored. It sweeps every operand pair in both modes on a five-bit instance, and it adds boundary pairs on a 32-bit instance.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;

    // Action of the W-bit arithmetic unit on one iteration.
    typedef enum logic [1:0] {
        AU_PASS = 2'd0,   // multiplier bit is 0: extend only
        AU_ADD  = 2'd1,   // fold multiplicand in
        AU_SUB  = 2'd2    // signed sign-bit step: take multiplicand out
    } au_op_e;

endpackage

// File: rtl/seq_mul_addsub.sv
module seq_mul_addsub
    import seq_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] part_i,
    input  logic [W-1:0] mcand_i,
    input  logic         sext_i,
    input  au_op_e       op_i,
    output logic [W:0]   sum_o
);

    logic [W:0] part_ext;
    logic [W:0] mcand_ext;

    always_comb begin
        part_ext  = {sext_i & part_i[W-1],  part_i};
        mcand_ext = {sext_i & mcand_i[W-1], mcand_i};
        unique case (op_i)
            AU_ADD:  sum_o = part_ext + mcand_ext;
            AU_SUB:  sum_o = part_ext - mcand_ext;
            default: sum_o = part_ext;
        endcase
    end

endmodule

// File: rtl/seq_mul_iter.sv
module seq_mul_iter #(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);

    localparam int CW = (W > 2) ? $clog2(W) : 1;

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == CW'(W - 1));

endmodule

// File: rtl/seq_mul.sv
module seq_mul
    import seq_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);

    localparam int AW = 2 * W;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          sgn;
        logic [W-1:0]  mcand;
        logic [AW-1:0] acc;
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic          accept;
    logic          last_step;
    au_op_e        au_op;
    logic [W:0]    au_sum;
    logic [AW-1:0] acc_shift;

    assign accept = start_i && !st_q.busy;

    seq_mul_iter #(.W(W)) u_iter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .step_i  (st_q.busy),
        .last_o  (last_step)
    );

    always_comb begin
        if (!st_q.busy || !st_q.acc[0]) begin
            au_op = AU_PASS;
        end else if (st_q.sgn && last_step) begin
            au_op = AU_SUB;
        end else begin
            au_op = AU_ADD;
        end
    end

    seq_mul_addsub #(.W(W)) u_au (
        .part_i  (st_q.acc[AW-1:W]),
        .mcand_i (st_q.mcand),
        .sext_i  (st_q.sgn),
        .op_i    (au_op),
        .sum_o   (au_sum)
    );

    // carry/sign bit of the sum becomes the new MSB
    assign acc_shift = {au_sum, st_q.acc[W-1:1]};

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.sgn   = signed_i;
            st_d.mcand = mcand_i;
            st_d.acc   = {{W{1'b0}}, mplier_i};
        end else if (st_q.busy) begin
            st_d.acc = acc_shift;
            if (last_step) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.hi   = acc_shift[AW-1:W];
                st_d.lo   = acc_shift[W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign hi_o   = st_q.hi;
    assign lo_o   = st_q.lo;

endmodule

// File: rtl/seq_mul_chk.sv
module seq_mul_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] hi_o,
    input logic [W-1:0] lo_o
);

    localparam int CW = $clog2(W + 1) + 1;

    logic [CW-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy_o) begin
            busy_run <= busy_run + CW'(1);
        end else begin
            busy_run <= '0;
        end
    end

    // R5
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_run == CW'(W)) && !busy_o);

    // R6
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= CW'(W));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hi_o) && $stable(lo_o)));

endmodule

bind seq_mul seq_mul_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
);

// File: tb/seq_mul_tb.sv
`timescale 1ns/1ps
module seq_mul_tb;

    localparam int SW = 5;
    localparam int LW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          s_start = 0, s_sgn = 0;
    logic [SW-1:0] s_a = '0, s_b = '0;
    logic          s_busy, s_done;
    logic [SW-1:0] s_hi, s_lo;

    logic          l_start = 0, l_sgn = 0;
    logic [LW-1:0] l_a = '0, l_b = '0;
    logic          l_busy, l_done;
    logic [LW-1:0] l_hi, l_lo;

    seq_mul #(.W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(s_start), .signed_i(s_sgn),
        .mcand_i(s_a), .mplier_i(s_b), .busy_o(s_busy), .done_o(s_done),
        .hi_o(s_hi), .lo_o(s_lo));

    seq_mul #(.W(LW)) u_dut32 (
        .clk(clk), .rst_n(rst_n), .start_i(l_start), .signed_i(l_sgn),
        .mcand_i(l_a), .mplier_i(l_b), .busy_o(l_busy), .done_o(l_done),
        .hi_o(l_hi), .lo_o(l_lo));

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input int w, input logic [31:0] a,
                                             input logic [31:0] b, input bit sgn);
        longint av, bv, p;
        av = longint'(a);
        bv = longint'(b);
        if (sgn && a[w-1]) av = av - (longint'(1) << w);
        if (sgn && b[w-1]) bv = bv - (longint'(1) << w);
        p = av * bv;
        if (w < 32) p = p & ((longint'(1) << (2 * w)) - 1);
        return 64'(p);
    endfunction

    // one operation on the small instance; stray = start during busy with new operands
    task automatic run_s(input logic [SW-1:0] a, input logic [SW-1:0] b,
                         input bit sgn, input bit stray);
        logic [63:0] exp, prev;
        int n;
        exp  = ref_prod(SW, 32'(a), 32'(b), sgn);
        prev = 64'({s_hi, s_lo});
        @(negedge clk);
        s_a = a; s_b = b; s_sgn = sgn; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        chk(s_busy, "R5", "busy after start", 64'(s_busy), 64'(1));
        if (stray) begin
            s_a = ~a; s_b = b + 1'b1; s_sgn = ~sgn;   // R8 inputs change mid-run
        end
        n = 0;
        while (!s_done && n < 100) begin
            @(negedge clk);
            n++;
            if (stray && n == 2) s_start = 1'b1;      // R6 start while busy
            if (stray && n == 3) s_start = 1'b0;
            if (n == 1 && !s_done)
                chk(64'({s_hi, s_lo}) == prev, "R7", "hold during busy",
                    64'({s_hi, s_lo}), prev);
        end
        s_start = 1'b0;
        chk(n == SW, stray ? "R6" : "R4", "done latency", 64'(n), 64'(SW));
        chk(!s_busy, "R5", "busy low at done", 64'(s_busy), 64'(0));
        chk(64'({s_hi, s_lo}) == exp, stray ? "R8" : (sgn ? "R3" : "R2"),
            "product", 64'({s_hi, s_lo}), exp);
        @(negedge clk);
        chk(!s_done, "R4", "done one cycle", 64'(s_done), 64'(0));
        chk(64'({s_hi, s_lo}) == exp, "R7", "hold after done",
            64'({s_hi, s_lo}), exp);
    endtask

    task automatic run_l(input logic [31:0] a, input logic [31:0] b, input bit sgn);
        logic [63:0] exp;
        int n;
        exp = ref_prod(LW, a, b, sgn);
        @(negedge clk);
        l_a = a; l_b = b; l_sgn = sgn; l_start = 1'b1;
        @(negedge clk);
        l_start = 1'b0;
        n = 0;
        while (!l_done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(n == LW, "R4", "done latency 32", 64'(n), 64'(LW));
        chk({l_hi, l_lo} == exp, sgn ? "R3" : "R2", "product 32", {l_hi, l_lo}, exp);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                failures++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!s_busy && !s_done, "R1", "flags in reset", 64'({s_busy, s_done}), 64'(0));
        chk({s_hi, s_lo} == '0, "R1", "result in reset", 64'({s_hi, s_lo}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!l_busy && !l_done && {l_hi, l_lo} == '0, "R1", "32-bit reset state",
            {l_hi, l_lo}, 64'(0));

        // exhaustive sweep, both modes (R2, R3)
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < (1 << SW); a++)
                for (int b = 0; b < (1 << SW); b++)
                    run_s(SW'(a), SW'(b), m[0], 1'b0);

        // R6 / R8 starts and operand changes while busy
        run_s(5'd13, 5'd7, 1'b0, 1'b1);
        run_s(5'd16, 5'd16, 1'b1, 1'b1);
        run_s(5'd31, 5'd3, 1'b1, 1'b1);

        // R3 / R2 boundaries on the full width
        run_l(32'h8000_0000, 32'h8000_0000, 1'b1);
        run_l(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_l(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        run_l(32'h7FFF_FFFF, 32'h8000_0000, 1'b1);
        run_l(32'h7FFF_FFFF, 32'h8000_0000, 1'b0);
        run_l(32'h1234_5678, 32'h9ABC_DEF0, 1'b0);
        run_l(32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
        run_l(32'h0000_0000, 32'hDEAD_BEEF, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule